// File: doc/BRIEF.md
# Decimal ASCII distance serializer

This block turns a binary distance reading into a short line of text for a byte-serial transmitter. When a reading arrives with its ready strobe, the block stores it. It clamps the stored value to the largest number that five decimal places can hold. It then hands out seven characters, one at a time: five decimal digits, most significant first, with leading zeros kept, followed by a carriage return and a line feed.

The sequencer runs on the fast system clock but moves only on cycles where a step enable is high. That enable matches the serial bit rate; in the intended system it is a 9600 Hz tick derived from 12 MHz. For each character the block waits until the transmitter reports that it is not busy. It then raises a send strobe for one clock together with the byte. After that it lets one step pass so that the transmitter can raise its busy flag.

The sequencer has three states:
- `ST_IDLE` goes to `ST_ISSUE` when a step sees the ready strobe, and the reading is captured at that point.
- `ST_ISSUE` goes to `ST_GUARD` on a step where busy is low, and that step emits the byte.
- `ST_GUARD` goes back to `ST_ISSUE` on the next step for the next character, or to `ST_IDLE` after the line feed.

Top module: `ascii_dist_serializer`

## Requirements
- R1: A reading is captured only on a step-enabled cycle in idle that sees `rdy_i` high. Changes on `dist_i` after that capture do not alter the characters of that line.
- R2: Character k of a line (k = 0..4) is the ASCII code 0x30 plus the decimal digit of the captured value with weight 10^(4-k). The ten-thousands digit goes first and leading zeros are sent, so 10 becomes "00010".
- R3: The sixth character is carriage return 0x0D and the seventh is line feed 0x0A. After these the block is idle and accepts the next reading.
- R4: An input above 99999 is stored as 99999 and is sent as "99999".
- R5: `tx_send_o` is high for exactly one clock per character. It rises only on an edge where `tx_busy_i` was sampled low, and `tx_byte_o` changes only together with it.
- R6: A ready strobe that arrives while a line is being sent is ignored. No extra characters appear and the line in progress keeps its digits.
- R7: `tx_send_o` rises only at an edge whose step enable was high.
- R8: While reset is held, `tx_send_o` is low and `tx_byte_o` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | One-clock enable at the serial bit rate |
| rdy_i | input | 1 | New reading is valid on `dist_i` |
| dist_i | input | DIST_W | Binary distance value |
| tx_busy_i | input | 1 | Transmitter is shifting a byte |
| tx_send_o | output | 1 | One-clock strobe that offers `tx_byte_o` |
| tx_byte_o | output | 8 | ASCII character being offered |

## Verification
Readings of 10, 0, 7, 12345, 54321 and 99999 check the digit weights and the handling of leading zeros. A value of 0 tells apart a correct zero padding from an empty field. Values of 100000 and the largest 20-bit input show the difference between clamping and plain truncation of high bits. Other runs scramble `dist_i` right after capture, pulse ready in the middle of a line, and hold busy for a long time. These separate a design that re-reads its input, one that restarts mid-line, and one that offers a byte without waiting for busy to drop.

// File: rtl/ds_pkg.sv
package ds_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_GUARD = 2'd2
    } seq_state_t;

    localparam logic [7:0] ASCII_ZERO = 8'h30;
    localparam logic [7:0] CHAR_CR    = 8'h0D;
    localparam logic [7:0] CHAR_LF    = 8'h0A;

    function automatic int pow10(input int k);
        int r;
        r = 1;
        for (int i = 0; i < k; i++) r = r * 10;
        return r;
    endfunction

endpackage

// File: rtl/ds_capture.sv
module ds_capture #(
    parameter int DIST_W = 20,
    parameter int NDIG   = 5,
    localparam int SAT   = ds_pkg::pow10(NDIG) - 1,
    localparam int VAL_W = $clog2(SAT + 1),
    localparam int CW    = (DIST_W > VAL_W) ? DIST_W : VAL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DIST_W-1:0] din,
    output logic [VAL_W-1:0]  held
);

    logic [CW-1:0] din_wide;
    logic [VAL_W-1:0] clamped;

    assign din_wide = CW'(din);

    always_comb begin
        if (din_wide > CW'(SAT))
            clamped = VAL_W'(SAT);
        else
            clamped = VAL_W'(din_wide);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            held <= '0;
        else if (load)
            held <= clamped;
    end

endmodule

// File: rtl/ds_digits.sv
module ds_digits #(
    parameter int NDIG  = 5,
    parameter int VAL_W = 17,
    parameter int IDX_W = 3
) (
    input  logic [VAL_W-1:0] val,
    input  logic [IDX_W-1:0] idx,
    output logic [7:0]       ch
);
    import ds_pkg::*;

    logic [3:0] dig [NDIG];

    for (genvar g = 0; g < NDIG; g++) begin : g_dig
        localparam int WEIGHT = pow10(NDIG - 1 - g);
        logic [VAL_W-1:0] quot;
        logic [VAL_W-1:0] rem;
        assign quot   = val / VAL_W'(WEIGHT);
        assign rem    = quot % VAL_W'(10);
        assign dig[g] = rem[3:0];
    end

    always_comb begin
        ch = CHAR_LF;
        if (idx == IDX_W'(NDIG))
            ch = CHAR_CR;
        for (int i = 0; i < NDIG; i++) begin
            if (idx == IDX_W'(i))
                ch = ASCII_ZERO + {4'b0000, dig[i]};
        end
    end

endmodule

// File: rtl/ds_seq.sv
module ds_seq #(
    parameter int IDX_W    = 3,
    parameter int LAST_IDX = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step_en,
    input  logic                rdy_i,
    input  logic                tx_busy_i,
    input  logic [7:0]          char_i,
    output logic                load_o,
    output logic [IDX_W-1:0]    idx_o,
    output logic                tx_send_o,
    output logic [7:0]          tx_byte_o,
    output ds_pkg::seq_state_t  state_o
);
    import ds_pkg::*;

    seq_state_t state, nxt;
    logic       fire;
    logic       at_last;

    assign at_last = (idx_o == IDX_W'(LAST_IDX));
    assign fire    = (state == ST_ISSUE) && step_en && !tx_busy_i;
    assign load_o  = (state == ST_IDLE) && step_en && rdy_i;
    assign state_o = state;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (step_en && rdy_i) nxt = ST_ISSUE;
            ST_ISSUE: if (fire)             nxt = ST_GUARD;
            ST_GUARD: if (step_en)          nxt = at_last ? ST_IDLE : ST_ISSUE;
            default:                        nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_send_o <= 1'b0;
            tx_byte_o <= 8'h00;
            idx_o     <= '0;
        end else begin
            tx_send_o <= 1'b0;
            if (load_o)
                idx_o <= '0;
            if (fire) begin
                tx_send_o <= 1'b1;
                tx_byte_o <= char_i;
            end
            if (state == ST_GUARD && step_en && !at_last)
                idx_o <= idx_o + 1'b1;
        end
    end

endmodule

// File: rtl/ascii_dist_serializer.sv
module ascii_dist_serializer #(
    parameter int DIST_W = 20,
    parameter int NDIG   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    input  logic              rdy_i,
    input  logic [DIST_W-1:0] dist_i,
    input  logic              tx_busy_i,
    output logic              tx_send_o,
    output logic [7:0]        tx_byte_o
);
    import ds_pkg::*;

    localparam int VAL_W    = $clog2(pow10(NDIG));
    localparam int LAST_IDX = NDIG + 1;
    localparam int IDX_W    = $clog2(LAST_IDX + 1);

    logic [VAL_W-1:0] held;
    logic [IDX_W-1:0] idx;
    logic [7:0]       ch;
    logic             load;
    seq_state_t       state;

    ds_capture #(.DIST_W(DIST_W), .NDIG(NDIG)) u_cap (
        .clk  (clk),
        .rst_n(rst_n),
        .load (load),
        .din  (dist_i),
        .held (held)
    );

    ds_digits #(.NDIG(NDIG), .VAL_W(VAL_W), .IDX_W(IDX_W)) u_dig (
        .val(held),
        .idx(idx),
        .ch (ch)
    );

    ds_seq #(.IDX_W(IDX_W), .LAST_IDX(LAST_IDX)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_en  (step_en),
        .rdy_i    (rdy_i),
        .tx_busy_i(tx_busy_i),
        .char_i   (ch),
        .load_o   (load),
        .idx_o    (idx),
        .tx_send_o(tx_send_o),
        .tx_byte_o(tx_byte_o),
        .state_o  (state)
    );

endmodule

// File: rtl/ds_checker.sv
module ds_checker (
    input logic               clk,
    input logic               rst_n,
    input logic               step_en,
    input logic               tx_busy_i,
    input logic               tx_send_o,
    input logic [7:0]         tx_byte_o,
    input ds_pkg::seq_state_t state
);
    import ds_pkg::*;

    p_send_when_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_send_o |-> !$past(tx_busy_i));

    p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_send_o |=> !tx_send_o);

    p_byte_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_send_o |-> $stable(tx_byte_o));

    p_on_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_send_o |-> $past(step_en));

    p_char_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_send_o |-> ((tx_byte_o >= 8'h30 && tx_byte_o <= 8'h39) ||
                       tx_byte_o == CHAR_CR || tx_byte_o == CHAR_LF));

    p_send_from_guard_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_send_o |-> (state == ST_GUARD));

    always @(negedge clk) begin
        if (!rst_n) begin
            p_reset_quiet_r8: assert (!tx_send_o && tx_byte_o == 8'h00);
        end
    end

endmodule

bind ascii_dist_serializer ds_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_en  (step_en),
    .tx_busy_i(tx_busy_i),
    .tx_send_o(tx_send_o),
    .tx_byte_o(tx_byte_o),
    .state    (state)
);

// File: tb/tb_ascii_dist_serializer.sv
module tb_ascii_dist_serializer;

    localparam int DIST_W = 20;

    typedef struct {
        logic [7:0] b;
        string      tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              step_en = 1'b0;
    logic              rdy_i = 1'b0;
    logic [DIST_W-1:0] dist_i = '0;
    logic              tx_busy_i = 1'b0;
    logic              tx_send_o;
    logic [7:0]        tx_byte_o;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    int   busy_len = 12;
    int   busy_cnt = 0;
    int   step_cnt = 0;
    logic prev_send = 1'b0;
    logic prev_step = 1'b0;
    bit   done = 0;

    ascii_dist_serializer #(.DIST_W(DIST_W), .NDIG(5)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_en  (step_en),
        .rdy_i    (rdy_i),
        .dist_i   (dist_i),
        .tx_busy_i(tx_busy_i),
        .tx_send_o(tx_send_o),
        .tx_byte_o(tx_byte_o)
    );

    always #5 clk = ~clk;

    // step enable: one clock in four
    always @(posedge clk) begin
        step_cnt <= (step_cnt == 3) ? 0 : step_cnt + 1;
        step_en  <= (step_cnt == 3);
    end

    // transmitter model
    always @(posedge clk) begin
        if (tx_send_o) begin
            tx_busy_i <= 1'b1;
            busy_cnt  <= busy_len;
        end else if (busy_cnt > 1) begin
            busy_cnt <= busy_cnt - 1;
        end else begin
            busy_cnt  <= 0;
            tx_busy_i <= 1'b0;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (tx_send_o) begin
                check(!prev_send, "R5 strobe width", 1, 0);
                check(!tx_busy_i, "R5 busy at send", int'(tx_busy_i), 0);
                check(prev_step, "R7 send off step", int'(prev_step), 1);
                if (exp_q.size() == 0) begin
                    check(0, "R6 unexpected byte", int'(tx_byte_o), -1);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(tx_byte_o == e.b, e.tag, int'(tx_byte_o), int'(e.b));
                end
            end
            prev_send = tx_send_o;
            prev_step = step_en;
        end
    end

    task automatic push_line(input int v, input string dtag);
        int s;
        exp_t e;
        s = (v > 99999) ? 99999 : v;
        for (int k = 4; k >= 0; k--) begin
            int w;
            w = 1;
            for (int j = 0; j < k; j++) w = w * 10;
            e.b   = 8'h30 + 8'((s / w) % 10);
            e.tag = dtag;
            exp_q.push_back(e);
        end
        e.b = 8'h0D; e.tag = "R3 CR"; exp_q.push_back(e);
        e.b = 8'h0A; e.tag = "R3 LF"; exp_q.push_back(e);
    endtask

    task automatic wait_drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (40) @(negedge clk);
    endtask

    // driver: offer one reading, then scramble the input
    task automatic send_reading(input int v, input string dtag, input bit mid_poke);
        push_line(v, dtag);
        @(negedge clk);
        dist_i = DIST_W'(v);
        rdy_i  = 1'b1;
        while (!step_en) @(negedge clk);
        @(negedge clk);
        rdy_i  = 1'b0;
        dist_i = ~DIST_W'(v);
        if (mid_poke) begin
            while (exp_q.size() > 4) @(negedge clk);
            dist_i = DIST_W'(4321);
            rdy_i  = 1'b1;
            repeat (9) @(negedge clk);
            rdy_i  = 1'b0;
        end
        wait_drain();
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!tx_send_o, "R8 send in reset", int'(tx_send_o), 0);
        check(tx_byte_o == 8'h00, "R8 byte in reset", int'(tx_byte_o), 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        check(!tx_send_o, "R1 no send without ready", int'(tx_send_o), 0);

        send_reading(10, "R2 digit", 0);
        send_reading(0, "R2 digit", 0);
        send_reading(7, "R2 digit", 0);
        send_reading(12345, "R2 digit", 0);
        send_reading(54321, "R1 latched digit", 0);
        send_reading(99999, "R2 digit", 0);
        send_reading(100000, "R4 saturated digit", 0);
        send_reading(1048575, "R4 saturated digit", 0);
        send_reading(801, "R6 digit under poke", 1);
        busy_len = 40;
        send_reading(60504, "R5 digit long busy", 0);
        busy_len = 12;
        send_reading(31, "R3 digit after idle", 0);

        check(exp_q.size() == 0, "R6 leftover expected", exp_q.size(), 0);
        repeat (200) @(negedge clk);
        check(!tx_send_o, "R6 quiet at end", int'(tx_send_o), 0);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

endmodule